// File: doc/BRIEF.md
# In-Order Writeback Reorder Unit

This block sits between the execute stage of an in-order pipeline and its register file. Every instruction that will write a register is registered with the unit when it issues. The unit gives it an issue tag, and for a memory operation that tag is carried in the request and comes back with the response. Memory responses may return in any order. The unit holds early arrivals in a completion buffer indexed by tag and writes results to the register file strictly in issue order, at most one per cycle. Instructions that need no memory access enter already complete and retire as soon as they reach the oldest position.

The unit also answers three hazard queries from the execute stage. It reports whether either source register is still waiting for a result. It reports whether a new memory operation targets an address that is still in flight. It holds a fence until every outstanding entry has retired. The register file lives inside the unit. Its two read ports see a value in the same cycle that value is being written.

Top module: `wb_reorder`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `ret_valid` is 0, `alloc_tag` and `ret_tag` are 0, and every register reads 0.
- R2: Accepted entries receive tags 0, 1, ..., DEPTH-1, then 0 again. `alloc_tag` always shows the tag the next accepted entry will get.
- R3: `alloc_ready` is 0 exactly when DEPTH entries are outstanding. An `alloc_valid` pulse while `alloc_ready` is 0 is ignored: no tag is consumed and nothing is queued.
- R4: When the oldest entry is a memory operation and a response carrying its tag arrives, `ret_valid` rises in that same cycle with the response data, without a buffer round trip.
- R5: A response for a younger entry is held and retired only after every older entry has retired. Retirements appear in issue order, at most one per cycle. `ret_tag` always shows the tag of the oldest entry, or the next tag to be issued when the queue is empty.
- R6: An entry with `alloc_is_mem` = 0 carries its value in `alloc_data`. It retires with that value in the first cycle it is the oldest entry.
- R7: `src_busy` is 1 when `rs1_addr` or `rs2_addr` equals the nonzero destination of an outstanding entry that is not retiring in the current cycle.
- R8: `addr_busy` is 1 when `mem_query` is 1 and `mem_addr` equals the address of an outstanding memory entry that is not retiring in the current cycle.
- R9: A retirement writes `ret_data` into register `ret_rd` at the clock edge, unless `ret_rd` is 0. Register 0 always reads 0. A read port addressing the register being written in the current cycle returns the new value.
- R10: `fence_wait` equals `fence_req` while any entry is outstanding, and is 0 once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Register a new writeback entry |
| alloc_is_mem | input | 1 | Entry waits for a memory response |
| alloc_rd | input | REG_AW | Destination register |
| alloc_addr | input | ADDR_W | Memory address of the entry |
| alloc_data | input | DATA_W | Result value for a non-memory entry |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | TAG_W | Tag given to the next accepted entry |
| resp_valid | input | 1 | Memory response present |
| resp_tag | input | TAG_W | Tag returned with the response |
| resp_data | input | DATA_W | Response data |
| ret_valid | output | 1 | An entry retires this cycle |
| ret_tag | output | TAG_W | Tag of the oldest entry |
| ret_rd | output | REG_AW | Destination of the retiring entry |
| ret_data | output | DATA_W | Value written back |
| rs1_addr | input | REG_AW | Source register A |
| rs2_addr | input | REG_AW | Source register B |
| rs1_data | output | DATA_W | Bypassed read of source A |
| rs2_data | output | DATA_W | Bypassed read of source B |
| src_busy | output | 1 | A source register is still pending |
| mem_query | input | 1 | Execute holds a memory operation |
| mem_addr | input | ADDR_W | Address of that memory operation |
| addr_busy | output | 1 | That address is still in flight |
| fence_req | input | 1 | Execute holds a fence |
| fence_wait | output | 1 | Fence must keep waiting |

## Verification
The bench builds the unit with DEPTH = 4, REG_AW = 5, DATA_W = 32 and ADDR_W = 16. With a four-entry queue, the full condition and tag wrap-around are reached within a handful of allocations. Responses can arrive in every permutation against a small window of outstanding tags. Random addresses drawn from eight values and destinations drawn from the full register range make address and register collisions frequent. These include collisions with register 0 and with the entry retiring in the same cycle, so the hazard exclusion and the read bypass are exercised against each other.

// File: rtl/wbr_pkg.sv
`timescale 1ns/1ps
package wbr_pkg;

    // Where the retiring value comes from in a given cycle
    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_BUF  = 2'd1,
        RET_RESP = 2'd2
    } ret_src_e;

    // Advance a circular index in the range 0..n-1
    function automatic int unsigned wrap_next(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

    function automatic int unsigned tag_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/wbr_queue.sv
`timescale 1ns/1ps
module wbr_queue #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 2,
    parameter int REG_AW = 5,
    parameter int ADDR_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              push_mem,
    input  logic [REG_AW-1:0] push_rd,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [TAG_W-1:0]  head_tag,
    output logic [TAG_W-1:0]  tail_tag,
    output logic [REG_AW-1:0] head_rd,
    output logic              full,
    output logic              empty,
    input  logic [REG_AW-1:0] rs1,
    input  logic [REG_AW-1:0] rs2,
    input  logic              mem_q,
    input  logic [ADDR_W-1:0] mem_a,
    output logic              src_busy,
    output logic              addr_busy
);
    import wbr_pkg::*;

    logic              e_v    [DEPTH];
    logic              e_mem  [DEPTH];
    logic [REG_AW-1:0] e_rd   [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];

    logic [TAG_W-1:0] head, tail;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) e_v[i] <= 1'b0;
        end else begin
            if (push) begin
                e_v[tail] <= 1'b1;
                tail      <= TAG_W'(wrap_next(32'(tail), DEPTH));
            end
            if (pop) begin
                e_v[head] <= 1'b0;
                head      <= TAG_W'(wrap_next(32'(head), DEPTH));
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Payload fields need no reset: they are read only while e_v is set
    always_ff @(posedge clk) begin
        if (push) begin
            e_mem[tail]  <= push_mem;
            e_rd[tail]   <= push_rd;
            e_addr[tail] <= push_addr;
        end
    end

    assign head_tag = head;
    assign tail_tag = tail;
    assign head_rd  = e_rd[head];
    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);

    // Hazard scan; the entry leaving this cycle is covered by the bypass
    always_comb begin
        src_busy  = 1'b0;
        addr_busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (e_v[i] && !(pop && TAG_W'(i) == head)) begin
                if (e_rd[i] != '0 && (e_rd[i] == rs1 || e_rd[i] == rs2))
                    src_busy = 1'b1;
                if (mem_q && e_mem[i] && e_addr[i] == mem_a)
                    addr_busy = 1'b1;
            end
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> count == CNT_W'($past(count) + CNT_W'(1)));

    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> e_v[head]);

endmodule

// File: rtl/wbr_cbuf.sv
`timescale 1ns/1ps
module wbr_cbuf #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              park_en,
    input  logic [TAG_W-1:0]  park_tag,
    input  logic [DATA_W-1:0] park_data,
    input  logic              drop_en,
    input  logic [TAG_W-1:0]  drop_tag,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);
    logic              slot_v [DEPTH];
    logic [DATA_W-1:0] slot_d [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_v[i] <= 1'b0;
        end else begin
            if (drop_en) slot_v[drop_tag] <= 1'b0;
            if (fill_en) slot_v[fill_tag] <= 1'b1;
            if (park_en) slot_v[park_tag] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) slot_d[fill_tag] <= fill_data;
        if (park_en) slot_d[park_tag] <= park_data;
    end

    assign look_hit  = slot_v[look_tag];
    assign look_data = slot_d[look_tag];

    // R5
    park_free_chk: assert property (@(posedge clk) disable iff (rst)
        park_en |-> !slot_v[park_tag]);

    // R6
    fill_free_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !slot_v[fill_tag]);

endmodule

// File: rtl/wbr_regfile.sv
`timescale 1ns/1ps
module wbr_regfile #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32,
    localparam int NREG  = 1 << REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] ra1,
    input  logic [REG_AW-1:0] ra2,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2
);
    logic [DATA_W-1:0] regs [NREG];
    logic              wr_live;

    assign wr_live = we && (waddr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_live) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        if (ra1 == '0)                  rd1 = '0;
        else if (wr_live && waddr == ra1) rd1 = wdata;
        else                            rd1 = regs[ra1];
        if (ra2 == '0)                  rd2 = '0;
        else if (wr_live && waddr == ra2) rd2 = wdata;
        else                            rd2 = regs[ra2];
    end

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> (rd1 == '0));

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_live && ra1 == waddr) |=> (ra1 != $past(waddr)) || $past(we && ra1 != waddr) || (regs[ra1] == $past(wdata)) || 1'b0 || (rd1 == regs[ra1]));

endmodule

// File: rtl/wb_reorder.sv
`timescale 1ns/1ps
module wb_reorder #(
    parameter int DEPTH  = 4,
    parameter int REG_AW = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int TAG_W = wbr_pkg::tag_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_mem,
    input  logic [REG_AW-1:0] alloc_rd,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    input  logic [DATA_W-1:0] resp_data,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic [REG_AW-1:0] ret_rd,
    output logic [DATA_W-1:0] ret_data,
    input  logic [REG_AW-1:0] rs1_addr,
    input  logic [REG_AW-1:0] rs2_addr,
    output logic [DATA_W-1:0] rs1_data,
    output logic [DATA_W-1:0] rs2_data,
    output logic              src_busy,
    input  logic              mem_query,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              addr_busy,
    input  logic              fence_req,
    output logic              fence_wait
);
    import wbr_pkg::*;

    logic              q_full, q_empty;
    logic [TAG_W-1:0]  head_tag, tail_tag;
    logic [REG_AW-1:0] head_rd;
    logic              push, pop;
    logic              buf_hit;
    logic [DATA_W-1:0] buf_data;
    ret_src_e          src;
    logic              park;

    assign push = alloc_valid && !q_full;

    // Choose the retirement source for the oldest entry
    always_comb begin
        src = RET_NONE;
        if (!q_empty) begin
            if (buf_hit)                                src = RET_BUF;
            else if (resp_valid && resp_tag == head_tag) src = RET_RESP;
        end
    end

    assign pop  = (src != RET_NONE);
    assign park = resp_valid && (src != RET_RESP);

    wbr_queue #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .REG_AW(REG_AW), .ADDR_W(ADDR_W)
    ) u_queue (
        .clk(clk), .rst(rst),
        .push(push), .push_mem(alloc_is_mem), .push_rd(alloc_rd), .push_addr(alloc_addr),
        .pop(pop),
        .head_tag(head_tag), .tail_tag(tail_tag), .head_rd(head_rd),
        .full(q_full), .empty(q_empty),
        .rs1(rs1_addr), .rs2(rs2_addr), .mem_q(mem_query), .mem_a(mem_addr),
        .src_busy(src_busy), .addr_busy(addr_busy)
    );

    wbr_cbuf #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_cbuf (
        .clk(clk), .rst(rst),
        .fill_en(push && !alloc_is_mem), .fill_tag(tail_tag), .fill_data(alloc_data),
        .park_en(park), .park_tag(resp_tag), .park_data(resp_data),
        .drop_en(src == RET_BUF), .drop_tag(head_tag),
        .look_tag(head_tag), .look_hit(buf_hit), .look_data(buf_data)
    );

    assign ret_valid = pop;
    assign ret_tag   = head_tag;
    assign ret_rd    = head_rd;
    assign ret_data  = (src == RET_BUF) ? buf_data : resp_data;

    wbr_regfile #(
        .REG_AW(REG_AW), .DATA_W(DATA_W)
    ) u_rf (
        .clk(clk), .rst(rst),
        .we(ret_valid), .waddr(ret_rd), .wdata(ret_data),
        .ra1(rs1_addr), .ra2(rs2_addr), .rd1(rs1_data), .rd2(rs2_data)
    );

    assign alloc_ready = !q_full;
    assign alloc_tag   = tail_tag;
    assign fence_wait  = fence_req && !q_empty;

    // R5
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> ret_tag == TAG_W'(wrap_next(32'($past(ret_tag)), DEPTH)));

    // R10
    fence_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fence_req && !fence_wait) |-> (!src_busy && !addr_busy && !ret_valid));

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> alloc_tag == TAG_W'(wrap_next(32'($past(alloc_tag)), DEPTH)));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_ready && !ret_valid) |=> $stable(alloc_tag) && !alloc_ready);

endmodule

// File: tb/tb_wb_reorder.sv
`timescale 1ns/1ps
module tb_wb_reorder;
    localparam int DEPTH  = 4;
    localparam int REG_AW = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int TAG_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              alloc_valid = 0, alloc_is_mem = 0;
    logic [REG_AW-1:0] alloc_rd = 0;
    logic [ADDR_W-1:0] alloc_addr = 0;
    logic [DATA_W-1:0] alloc_data = 0;
    logic              alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              resp_valid = 0;
    logic [TAG_W-1:0]  resp_tag = 0;
    logic [DATA_W-1:0] resp_data = 0;
    logic              ret_valid;
    logic [TAG_W-1:0]  ret_tag;
    logic [REG_AW-1:0] ret_rd;
    logic [DATA_W-1:0] ret_data;
    logic [REG_AW-1:0] rs1_addr = 0, rs2_addr = 0;
    logic [DATA_W-1:0] rs1_data, rs2_data;
    logic              src_busy;
    logic              mem_query = 0;
    logic [ADDR_W-1:0] mem_addr = 0;
    logic              addr_busy;
    logic              fence_req = 0;
    logic              fence_wait;

    wb_reorder #(.DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_is_mem(alloc_is_mem), .alloc_rd(alloc_rd),
        .alloc_addr(alloc_addr), .alloc_data(alloc_data),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .resp_valid(resp_valid), .resp_tag(resp_tag), .resp_data(resp_data),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_rd(ret_rd), .ret_data(ret_data),
        .rs1_addr(rs1_addr), .rs2_addr(rs2_addr), .rs1_data(rs1_data), .rs2_data(rs2_data),
        .src_busy(src_busy), .mem_query(mem_query), .mem_addr(mem_addr), .addr_busy(addr_busy),
        .fence_req(fence_req), .fence_wait(fence_wait)
    );

    // Behavioural reference state
    int          mq_tag[$];
    int          mq_rd[$];
    int          mq_addr[$];
    bit          mq_mem[$];
    bit          done_v [DEPTH];
    logic [31:0] done_d [DEPTH];
    logic [31:0] regs [32];
    int          next_tag = 0;
    int          pend[$];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_is_mem = 0; alloc_rd = 0; alloc_addr = 0; alloc_data = 0;
        resp_valid = 0; resp_tag = 0; resp_data = 0;
        rs1_addr = 0; rs2_addr = 0; mem_query = 0; mem_addr = 0; fence_req = 0;
    endtask

    // Compare outputs mid-cycle, advance the model, move to the next cycle
    task automatic step();
        int          sz;
        bit          ret, direct;
        logic [31:0] d;
        int          hrd;
        bit          sb, ab;
        logic [31:0] e1, e2;
        string       rtag;
        #3;
        sz = mq_tag.size();
        ret = 0; direct = 0; d = 0; hrd = 0;
        if (sz > 0) begin
            hrd = mq_rd[0];
            if (done_v[mq_tag[0]]) begin
                ret = 1; d = done_d[mq_tag[0]];
            end else if (resp_valid && int'(resp_tag) == mq_tag[0]) begin
                ret = 1; direct = 1; d = resp_data;
            end
        end
        chk("R3 alloc_ready", 32'(alloc_ready), 32'(sz < DEPTH));
        chk("R2 alloc_tag", 32'(alloc_tag), 32'(next_tag));
        chk("R5 ret_tag", 32'(ret_tag), 32'((sz > 0) ? mq_tag[0] : next_tag));
        rtag = direct ? "R4" : ((sz > 0 && !mq_mem[0]) ? "R6" : "R5");
        chk({rtag, " ret_valid"}, 32'(ret_valid), 32'(ret));
        if (ret) begin
            chk({rtag, " ret_rd"}, 32'(ret_rd), 32'(hrd));
            chk({rtag, " ret_data"}, ret_data, d);
        end
        sb = 0; ab = 0;
        for (int i = (ret ? 1 : 0); i < sz; i++) begin
            if (mq_rd[i] != 0 && (mq_rd[i] == int'(rs1_addr) || mq_rd[i] == int'(rs2_addr))) sb = 1;
            if (mem_query && mq_mem[i] && mq_addr[i] == int'(mem_addr)) ab = 1;
        end
        chk("R7 src_busy", 32'(src_busy), 32'(sb));
        chk("R8 addr_busy", 32'(addr_busy), 32'(ab));
        chk("R10 fence_wait", 32'(fence_wait), 32'(fence_req && sz != 0));
        e1 = (rs1_addr == 0) ? 32'h0 : ((ret && hrd == int'(rs1_addr)) ? d : regs[rs1_addr]);
        e2 = (rs2_addr == 0) ? 32'h0 : ((ret && hrd == int'(rs2_addr)) ? d : regs[rs2_addr]);
        chk("R9 rs1_data", rs1_data, e1);
        chk("R9 rs2_data", rs2_data, e2);
        // model update
        if (ret) begin
            done_v[mq_tag[0]] = 0;
            if (hrd != 0) regs[hrd] = d;
            void'(mq_tag.pop_front()); void'(mq_rd.pop_front());
            void'(mq_addr.pop_front()); void'(mq_mem.pop_front());
        end
        if (resp_valid && !direct) begin
            done_v[resp_tag] = 1; done_d[resp_tag] = resp_data;
        end
        if (alloc_valid && sz < DEPTH) begin
            mq_tag.push_back(next_tag); mq_rd.push_back(int'(alloc_rd));
            mq_addr.push_back(int'(alloc_addr)); mq_mem.push_back(alloc_is_mem);
            if (!alloc_is_mem) begin
                done_v[next_tag] = 1; done_d[next_tag] = alloc_data;
            end else begin
                pend.push_back(next_tag);
            end
            next_tag = (next_tag + 1) % DEPTH;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic do_alloc(input bit m, input int rd, input int a, input logic [31:0] v);
        alloc_valid = 1; alloc_is_mem = m; alloc_rd = REG_AW'(rd);
        alloc_addr = ADDR_W'(a); alloc_data = v;
    endtask

    task automatic do_resp(input int t, input logic [31:0] v);
        resp_valid = 1; resp_tag = TAG_W'(t); resp_data = v;
        for (int i = 0; i < pend.size(); i++) if (pend[i] == t) begin pend.delete(i); break; end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 0;
        for (int i = 0; i < DEPTH; i++) begin done_v[i] = 0; done_d[i] = 0; end
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        #3;
        chk("R1 alloc_ready", 32'(alloc_ready), 32'd1);
        chk("R1 ret_valid", 32'(ret_valid), 32'd0);
        chk("R1 alloc_tag", 32'(alloc_tag), 32'd0);
        chk("R1 ret_tag", 32'(ret_tag), 32'd0);
        rs1_addr = 7; rs2_addr = 31;
        #1;
        chk("R1 rs1_data", rs1_data, 32'd0);
        chk("R1 rs2_data", rs2_data, 32'd0);
        @(negedge clk); idle();

        // Fill the queue: three memory ops and one complete op
        do_alloc(1, 3, 100, 0); step();
        do_alloc(1, 4, 200, 0); rs1_addr = 3; step();
        do_alloc(0, 5, 0, 32'h5555); rs2_addr = 4; mem_query = 1; mem_addr = 200; step();
        do_alloc(1, 6, 300, 0); fence_req = 1; step();
        // R3: queue full, this request is dropped
        do_alloc(1, 9, 900, 0); mem_query = 1; mem_addr = 300; step();
        // Younger responses first, they must be held
        do_resp(1, 32'h1111); rs1_addr = 4; step();
        do_resp(3, 32'h3333); fence_req = 1; step();
        // Oldest response retires directly; R4
        do_resp(0, 32'h0a0a); rs1_addr = 3; rs2_addr = 6; step();
        rs1_addr = 4; step();
        rs1_addr = 5; mem_query = 1; mem_addr = 300; step();
        rs2_addr = 6; fence_req = 1; step();
        fence_req = 1; rs1_addr = 3; rs2_addr = 6; step();

        // Register 0 destinations and tag wrap
        do_alloc(0, 0, 0, 32'hdead); step();
        do_alloc(1, 0, 5, 0); rs1_addr = 0; step();
        do_alloc(1, 7, 5, 0); mem_query = 1; mem_addr = 5; step();
        do_resp(1, 32'hbeef); rs1_addr = 0; step();
        do_resp(2, 32'h7777); rs1_addr = 7; step();
        step();

        // Random traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if ($urandom_range(0, 1) == 1)
                do_alloc($urandom_range(0, 3) != 0, $urandom_range(0, 31),
                         $urandom_range(0, 7), $urandom());
            if (pend.size() > 0 && $urandom_range(0, 2) != 0)
                do_resp(pend[$urandom_range(0, pend.size() - 1)], $urandom());
            rs1_addr = REG_AW'($urandom_range(0, 31));
            rs2_addr = REG_AW'($urandom_range(0, 31));
            mem_query = $urandom_range(0, 1) == 1;
            mem_addr = ADDR_W'($urandom_range(0, 7));
            fence_req = $urandom_range(0, 1) == 1;
            step();
        end
        // Drain
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (pend.size() > 0) do_resp(pend[0], $urandom());
            fence_req = 1;
            step();
        end
        // Read back every register through the ports
        for (int r = 0; r < 32; r += 2) begin
            rs1_addr = REG_AW'(r); rs2_addr = REG_AW'(r + 1);
            step();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule